// File: doc/BRIEF.md
# Programmable Counter/Timer with Joint Mode and Clock Selection

This block is a down-counter that sits beside a two-channel serial controller. It runs in one of two modes. In counting mode it measures out a number of events from a chosen source. In timing mode it produces a square wave from a chosen time base. A single 3-bit selector picks the mode and the event source together. The sources are a general-purpose input pin, the 1x transmit clock of either serial channel, and the system (crystal) clock. Some codes also pass the source through a divide-by-16 prescaler.

Software places a selector code and a preload value on the control pins and pulses `start_i`. At that edge the block captures both values and loads the counter. It then counts down once per qualified source event. The output `ready_o` feeds the interrupt logic. In counting mode it flags terminal count. In timing mode it flags each rising edge of the square wave. Pulsing `stop_i` halts counting and clears the flag. All pins are plain level or pulse control and status signals, with no handshake.

Top module: `ctmr_top`

## Requirements
- R1: After reset, `count_o` is 0, `wave_o` is 0, `ready_o` is 0 and `running_o` is 0.
- R2: The selector code decodes as follows, with bit 2 alone choosing timing mode (1) or counting mode (0). Code 0 counts the pin `ext_pin_i`, 1 counts `txa_clk_i`, 2 counts `txb_clk_i`, and 3 counts the system clock divided by 16. Code 4 times on `ext_pin_i`, 5 on `ext_pin_i` divided by 16, 6 on every system clock cycle, and 7 on the system clock divided by 16. Sources that are not selected have no effect.
- R3: A cycle with `start_i` high captures the selector and `preload_i`, loads `count_o` with the preload, clears `wave_o` and `ready_o`, and sets `running_o`. The counter then moves once per source event. With the undivided system clock, it moves on every edge after the start edge.
- R4: In counting mode, a source event while `count_o` is 0 sets `ready_o` and wraps `count_o` to all ones. Counting then goes on downward. Any other event decrements `count_o`. `wave_o` stays 0 in this mode.
- R5: In timing mode, a source event while `count_o` is 0 reloads the captured preload and toggles `wave_o`. Any other event decrements. A preload of P therefore gives a half period of P+1 events.
- R6: In timing mode, `ready_o` is set by every 0-to-1 transition of `wave_o`. It stays set until the next start or stop.
- R7: A cycle with `stop_i` high and `start_i` low clears `ready_o` and `running_o`. `count_o` and `wave_o` then hold regardless of source events until the next start.
- R8: Changes on `mode_sel_i` or `preload_i` while running have no effect. A new selector, and the value used for timing-mode reloads, are taken only at a start.
- R9: The divide-by-16 prescaler is cleared at every start. A divided source therefore produces its first count after exactly 16 source events, and one more after every further 16.
- R10: The three external source pins are synchronised and counted on rising edges only. A pin held high for many cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (crystal) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel_i | input | 3 | Mode and source selector, captured at start |
| preload_i | input | 16 | Preload value, captured at start |
| start_i | input | 1 | Start command, one cycle |
| stop_i | input | 1 | Stop command, one cycle |
| ext_pin_i | input | 1 | General-purpose source pin |
| txa_clk_i | input | 1 | Channel A 1x transmit clock |
| txb_clk_i | input | 1 | Channel B 1x transmit clock |
| count_o | output | 16 | Current counter value |
| wave_o | output | 1 | Timing-mode square-wave output |
| ready_o | output | 1 | Ready flag toward interrupt logic |
| running_o | output | 1 | Counter is running |

## Verification
The bench builds the block with its defaults: a 16-bit counter, a 4-bit prescaler (divide by 16) and two synchroniser stages. Because preloads stay small, terminal count and several full wave periods fall within a few dozen events. A preload of zero brings the wrap to all ones within one event. The 16-event prescaler window is short enough that the bench can check its boundary on both sides, at 15 and 16 cycles after a start. At the same time, the full 16-bit width is kept for the wrap value.

// File: rtl/ctmr_pkg.sv
`timescale 1ns/1ps
package ctmr_pkg;

  typedef enum logic [1:0] {
    SRC_PIN  = 2'd0,
    SRC_TXA  = 2'd1,
    SRC_TXB  = 2'd2,
    SRC_SYS  = 2'd3
  } ctmr_src_e;

  typedef struct packed {
    logic      timer;
    ctmr_src_e src;
    logic      div;
  } ctmr_sel_t;

  localparam int unsigned NUM_PINS = 3;

  // Code bit 2 alone picks the mode; the low bits pick source and divider.
  function automatic ctmr_sel_t ctmr_decode(input logic [2:0] code);
    ctmr_sel_t s;
    s.timer = code[2];
    case (code)
      3'd0:    begin s.src = SRC_PIN; s.div = 1'b0; end
      3'd1:    begin s.src = SRC_TXA; s.div = 1'b0; end
      3'd2:    begin s.src = SRC_TXB; s.div = 1'b0; end
      3'd3:    begin s.src = SRC_SYS; s.div = 1'b1; end
      3'd4:    begin s.src = SRC_PIN; s.div = 1'b0; end
      3'd5:    begin s.src = SRC_PIN; s.div = 1'b1; end
      3'd6:    begin s.src = SRC_SYS; s.div = 1'b0; end
      default: begin s.src = SRC_SYS; s.div = 1'b1; end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ctmr_sync_edge.sv
`timescale 1ns/1ps
module ctmr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;

  // R10
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/ctmr_clk_sel.sv
`timescale 1ns/1ps
module ctmr_clk_sel
  import ctmr_pkg::*;
#(
  parameter int unsigned PRESC_W     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctmr_sel_t           cfg_i,
  input  logic                restart_i,
  input  logic                run_i,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic                tick_o
);
  localparam logic [PRESC_W-1:0] PRESC_LAST = {PRESC_W{1'b1}};

  logic [NUM_PINS-1:0] rise;
  logic                raw_evt;
  logic                wrap;
  logic [PRESC_W-1:0]  presc_q;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    ctmr_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din_i (pins_i[g]),
      .rise_o(rise[g])
    );
  end

  always_comb begin
    case (cfg_i.src)
      SRC_PIN: raw_evt = rise[0];
      SRC_TXA: raw_evt = rise[1];
      SRC_TXB: raw_evt = rise[2];
      default: raw_evt = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) presc_q <= '0;
    else if (run_i && raw_evt) presc_q <= presc_q + 1'b1;
  end

  assign wrap   = raw_evt && (presc_q == PRESC_LAST);
  assign tick_o = run_i && (cfg_i.div ? wrap : raw_evt);

  // R9
  div_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.div && tick_o && !restart_i) |=> !tick_o);

endmodule

// File: rtl/ctmr_core.sv
`timescale 1ns/1ps
module ctmr_core #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             timer_i,
  input  logic [WIDTH-1:0] preload_i,
  input  logic             tick_i,
  output logic [WIDTH-1:0] count_o,
  output logic             wave_o,
  output logic             ready_o,
  output logic             running_o
);
  logic [WIDTH-1:0] reload_q;
  logic             at_zero;

  assign at_zero = (count_o == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o   <= '0;
      reload_q  <= '0;
      wave_o    <= 1'b0;
      ready_o   <= 1'b0;
      running_o <= 1'b0;
    end else if (start_i) begin
      count_o   <= preload_i;
      reload_q  <= preload_i;
      wave_o    <= 1'b0;
      ready_o   <= 1'b0;
      running_o <= 1'b1;
    end else if (stop_i) begin
      ready_o   <= 1'b0;
      running_o <= 1'b0;
    end else if (running_o && tick_i) begin
      if (!at_zero) begin
        count_o <= count_o - 1'b1;
      end else if (timer_i) begin
        count_o <= reload_q;
        wave_o  <= ~wave_o;
        if (!wave_o) ready_o <= 1'b1;
      end else begin
        count_o <= '1;
        ready_o <= 1'b1;
      end
    end
  end

  // R7
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> (!ready_o && !running_o));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !start_i) |=> ($stable(count_o) && $stable(wave_o)));

  // R6
  rise_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && timer_i && $rose(wave_o)) |-> ready_o);

  // R4
  counter_wave_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !timer_i) |-> !wave_o);

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (count_o == $past(preload_i) && running_o && !ready_o && !wave_o));

endmodule

// File: rtl/ctmr_top.sv
`timescale 1ns/1ps
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned PRESC_W     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_sel_i,
  input  logic [WIDTH-1:0] preload_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             ext_pin_i,
  input  logic             txa_clk_i,
  input  logic             txb_clk_i,
  output logic [WIDTH-1:0] count_o,
  output logic             wave_o,
  output logic             ready_o,
  output logic             running_o
);
  ctmr_sel_t           act_q;
  logic                tick;
  logic [NUM_PINS-1:0] pins;

  assign pins = {txb_clk_i, txa_clk_i, ext_pin_i};

  always_ff @(posedge clk) begin
    if (!rst_n)       act_q <= ctmr_decode(3'd0);
    else if (start_i) act_q <= ctmr_decode(mode_sel_i);
  end

  ctmr_clk_sel #(.PRESC_W(PRESC_W), .SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_i    (act_q),
    .restart_i(start_i),
    .run_i    (running_o),
    .pins_i   (pins),
    .tick_o   (tick)
  );

  ctmr_core #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .timer_i  (act_q.timer),
    .preload_i(preload_i),
    .tick_i   (tick),
    .count_o  (count_o),
    .wave_o   (wave_o),
    .ready_o  (ready_o),
    .running_o(running_o)
  );

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(act_q));

endmodule

// File: tb/ctmr_top_tb_top.sv
`timescale 1ns/1ps
module ctmr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic [15:0] preload = 16'd0;
  logic        start = 1'b0, stop = 1'b0;
  logic        ext = 1'b0, txa = 1'b0, txb = 1'b0;
  logic [15:0] count;
  logic        wave, ready, running;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ctmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel_i(mode_sel), .preload_i(preload),
    .start_i(start), .stop_i(stop), .ext_pin_i(ext), .txa_clk_i(txa),
    .txb_clk_i(txb), .count_o(count), .wave_o(wave), .ready_o(ready),
    .running_o(running)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model from R4/R5/R6: state after t events from a start with preload p.
  function automatic void model(input bit tm, input int p, input int t,
                                output logic [15:0] c, output logic w, output logic r);
    c = p[15:0]; w = 1'b0; r = 1'b0;
    for (int i = 0; i < t; i++) begin
      if (c != 16'd0) c = c - 16'd1;
      else if (tm) begin c = p[15:0]; if (!w) r = 1'b1; w = ~w; end
      else begin c = 16'hFFFF; r = 1'b1; end
    end
  endfunction

  // Source index from R2: 0 ext pin, 1 txa, 2 txb, 3 system clock.
  function automatic int src_of(input logic [2:0] code);
    case (code)
      3'd0, 3'd4, 3'd5: return 0;
      3'd1: return 1;
      3'd2: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic bit div_of(input logic [2:0] code);
    return (code == 3'd3) || (code == 3'd5) || (code == 3'd7);
  endfunction

  task automatic do_start(input logic [2:0] code, input logic [15:0] p);
    @(negedge clk); mode_sel = code; preload = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  // One rising edge on the selected pin (idx<3) plus optional decoys on the others.
  task automatic pulse(input int idx, input bit decoy);
    logic [2:0] v;
    v = (idx < 3) ? (3'b001 << idx) : 3'b000;
    if (decoy) v = v | (3'($urandom % 8) & ~v);
    @(negedge clk); {txb, txa, ext} = v;
    repeat (3) @(negedge clk);
    {txb, txa, ext} = 3'b000;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_state(input string tag, input bit tm, input int p, input int t);
    logic [15:0] c; logic w, r;
    model(tm, p, t, c, w, r);
    chk({tag, " count"}, count, c);
    chk({tag, " wave"}, {15'd0, wave}, {15'd0, w});
    chk({tag, " ready"}, {15'd0, ready}, {15'd0, r});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 16'd0);
    chk("R1 flags", {12'd0, wave, ready, running, 1'b0}, 16'd0);

    // R3 start, R4 wrap from preload 0 on ext pin counting
    do_start(3'd0, 16'd0);
    chk("R3 load", count, 16'd0);
    chk("R3 running", {15'd0, running}, 16'd1);
    pulse(0, 1'b0);
    chk("R4 wrap", count, 16'hFFFF);
    chk("R4 ready", {15'd0, ready}, 16'd1);
    pulse(0, 1'b0);
    chk("R4 continue", count, 16'hFFFE);

    // R5/R6 timing on every system clock, preload 3
    do_start(3'd6, 16'd3);
    repeat (4) @(negedge clk);
    expect_state("R5 half", 1'b1, 3, 4);
    chk("R6 rise ready", {15'd0, ready}, 16'd1);
    repeat (4) @(negedge clk);
    chk("R5 fall", {15'd0, wave}, 16'd0);

    // R7 stop clears ready and freezes count
    do_stop();
    chk("R7 ready clr", {15'd0, ready}, 16'd0);
    begin
      logic [15:0] held;
      held = count;
      repeat (20) @(negedge clk);
      chk("R7 hold", count, held);
      chk("R7 not running", {15'd0, running}, 16'd0);
    end

    // R9 prescaler boundary on system clock / 16
    do_start(3'd3, 16'd5);
    repeat (15) @(negedge clk);
    chk("R9 before 16", count, 16'd5);
    @(negedge clk);
    chk("R9 at 16", count, 16'd4);

    // R10 level held high counts once
    do_start(3'd4, 16'd9);
    @(negedge clk); ext = 1'b1;
    repeat (12) @(negedge clk); ext = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 single", count, 16'd8);

    // R2 unselected sources ignored
    do_start(3'd1, 16'd7);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); {txb, ext} = 2'b11;
      repeat (3) @(negedge clk); {txb, ext} = 2'b00;
      repeat (3) @(negedge clk);
    end
    chk("R2 decoys ignored", count, 16'd7);
    pulse(1, 1'b0);
    chk("R2 txa counts", count, 16'd6);

    // R8 selector and preload changes while running
    do_start(3'd0, 16'd10);
    @(negedge clk); mode_sel = 3'd6; preload = 16'd99;
    repeat (20) @(negedge clk);
    chk("R8 sel ignored", count, 16'd10);
    pulse(0, 1'b0);
    chk("R8 still pin", count, 16'd9);
    do_start(3'd4, 16'd2);
    @(negedge clk); preload = 16'd50;
    for (int i = 0; i < 3; i++) pulse(0, 1'b0);
    chk("R8 reload captured", count, 16'd2);
    chk("R8 wave", {15'd0, wave}, 16'd1);

    // Random mix across all codes
    for (int it = 0; it < 40; it++) begin
      logic [2:0] code; int p, src, n, ev; bit dv;
      code = 3'($urandom % 8);
      p    = $urandom % 20;
      src  = src_of(code);
      dv   = div_of(code);
      do_start(code, p[15:0]);
      if (src == 3) begin
        n = $urandom % 300;
        repeat (n) @(negedge clk);
      end else begin
        n = dv ? ($urandom % 70) : ($urandom % 40);
        for (int k = 0; k < n; k++) pulse(src, 1'b1);
      end
      ev = dv ? n / 16 : n;
      // R2 R4 R5 R6 R9 random
      expect_state($sformatf("R2 rand code%0d", code), code[2], p, ev);
      if (($urandom % 3) == 0) begin
        logic [15:0] h;
        do_stop();
        h = count;
        chk("R7 rand ready", {15'd0, ready}, 16'd0);
        if (src < 3) pulse(src, 1'b0); else repeat (20) @(negedge clk);
        chk("R7 rand hold", count, h);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule